// File: doc/BRIEF.md
# Accumulator ALU with skip-compare

This block is the arithmetic and logic stage of a small accumulator machine. Operand A comes from the long-term cache register and operand B comes from the operand path, which carries either a constant or a register value. The instruction's 4-bit opcode selects one of three things. It can be a word operation: add, subtract, the five bitwise functions or a one-bit shift. It can be an unsigned test that compares A with B. Or it can be an opcode that the ALU does not handle at all.

The surrounding sequencer raises `capture` for one clock in the execute phase of each instruction. On that edge, a word operation loads its outcome into the result register. A test loads the skip request instead: the request is high when the test came out false, and it tells the sequencer to step over the next instruction. The result register keeps its value across tests and across opcodes that do not belong to the ALU. The skip request is cleared by every capture that is not a failed test. When `capture` is low, both outputs hold.

Top module: `acc_alu_skip`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes 0 and `skip_req` becomes 0 after that edge.
- R2: A capture with opcode 0100 loads (A+B) mod 256 into `result`. A capture with opcode 0101 loads (A-B) mod 256.
- R3: A capture with one of the bitwise opcodes loads the matching function of A and B into `result`: 0111 gives AND, 1000 gives OR, 1001 gives NAND, 1010 gives NOR and 1011 gives XOR.
- R4: A capture with opcode 1010 and A equal to 0 loads the bitwise inverse of B, so the opcode acts as NOT B.
- R5: A capture with opcode 1100, 1101 or 1110 tests A==B, A>B or A<B respectively, unsigned. After that edge, `skip_req` is 1 exactly when the test is false, and `result` is unchanged.
- R6: A capture with opcode 1111 loads A shifted by one position, with a zero filled in. B bit 0 chooses the direction: 0 shifts left and 1 shifts right.
- R7: A capture with opcode 0000, 0001, 0010, 0011 or 0110 leaves `result` unchanged.
- R8: Every capture whose opcode is not a test (1100, 1101, 1110) sets `skip_req` to 0.
- R9: At an edge where `capture` is 0, `result` and `skip_req` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| capture | input | 1 | Execute-phase strobe; outputs update only on edges where this is high |
| opcode | input | 4 | Instruction opcode |
| a_val | input | 8 | Operand A, taken from the cache register |
| b_val | input | 8 | Operand B, a constant or a register value |
| result | output | 8 | Registered result of the last word operation |
| skip_req | output | 1 | High after a failed test, asking the sequencer to skip the next instruction |

## Verification
The directed patterns aim at the points where a plausible mistake changes the output:
- Operand pairs whose sum wraps past 255, or whose difference goes below zero, expose a lost modulo.
- A equal to 0 with opcode 1010 checks the NOT case.
- Operand pairs that are equal, one apart, and at 0 and 255 separate the three tests and their false outcomes, and catch any signed comparison.
- The value 0x81 shifted both ways shows whether the edge bit drops out, whether a zero is filled in, and which value of B bit 0 gives which direction.

After that, a long stream of random opcodes, operands and strobe values is compared against a behavioural model on every clock. That stream mixes word operations and tests with non-ALU opcodes and idle cycles, so it also shows that the result held across tests, idle cycles and foreign opcodes is the right one.

// File: rtl/acc_alu_pkg.sv
// Package acc_alu_pkg
// Holds the opcode encoding and the operation classes shared by the ALU units.
// Assumes a 4-bit opcode. Only the encodings listed here are decoded.
package acc_alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_JUMP  = 4'b0000,
        OP_LOAD  = 4'b0001,
        OP_PUT   = 4'b0010,
        OP_GET   = 4'b0011,
        OP_ADD   = 4'b0100,
        OP_SUB   = 4'b0101,
        OP_MOVE  = 4'b0110,
        OP_AND   = 4'b0111,
        OP_OR    = 4'b1000,
        OP_NAND  = 4'b1001,
        OP_NOR   = 4'b1010,
        OP_XOR   = 4'b1011,
        OP_EQ    = 4'b1100,
        OP_GT    = 4'b1101,
        OP_LT    = 4'b1110,
        OP_SHIFT = 4'b1111
    } op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ARITH = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_TEST  = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        LG_AND  = 3'd0,
        LG_OR   = 3'd1,
        LG_NAND = 3'd2,
        LG_NOR  = 3'd3,
        LG_XOR  = 3'd4
    } logic_sel_e;

    typedef enum logic [1:0] {
        TS_EQ = 2'd0,
        TS_GT = 2'd1,
        TS_LT = 2'd2
    } test_sel_e;

    // Returns the operation class of an opcode; the shift counts as arithmetic
    function automatic cls_e class_of(input op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_SHIFT:              class_of = CLS_ARITH;
            OP_AND, OP_OR, OP_NAND, OP_NOR, OP_XOR: class_of = CLS_LOGIC;
            OP_EQ, OP_GT, OP_LT:                   class_of = CLS_TEST;
            default:                               class_of = CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu_arith_unit.sv
// Module alu_arith_unit
// Adds or subtracts two words, modulo 2**W.
// Assumes: 'sub' is high to subtract. No carry is produced or consumed.
module alu_arith_unit #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum_full;

    // Forms the two's-complement operand: B, or ~B with a carry-in of one
    always_comb begin
        b_eff    = sub ? ~b : b;
        sum_full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    end

    // The carry out is dropped, which wraps the sum modulo 2**W
    assign y = sum_full[W-1:0];

endmodule

// File: rtl/alu_bitwise_unit.sv
// Module alu_bitwise_unit
// Applies one of five bitwise functions to two words, using one slice per bit.
// Assumes: 'sel' carries a logic_sel_e code; any other code gives zero.
module alu_bitwise_unit
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_slice
            logic and_b, or_b, xor_b;

            // Shared gate terms of this bit
            always_comb begin
                and_b = a[i] & b[i];
                or_b  = a[i] | b[i];
                xor_b = a[i] ^ b[i];
            end

            // Picks the requested function for this bit
            always_comb begin
                case (sel)
                    LG_AND:  y[i] = and_b;
                    LG_OR:   y[i] = or_b;
                    LG_NAND: y[i] = ~and_b;
                    LG_NOR:  y[i] = ~or_b;
                    LG_XOR:  y[i] = xor_b;
                    default: y[i] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/alu_shift_unit.sv
// Module alu_shift_unit
// Shifts a word by one position and fills the vacated bit with zero.
// Assumes: 'right' is high for a right shift and low for a left shift.
module alu_shift_unit #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic         right,
    output logic [W-1:0] y
);
    // Selects the direction of the single-place move
    always_comb begin
        if (right) y = {1'b0, a[W-1:1]};
        else       y = {a[W-2:0], 1'b0};
    end

endmodule

// File: rtl/alu_compare_unit.sv
// Module alu_compare_unit
// Runs an unsigned equality or magnitude test of A against B and flags a false outcome.
// Assumes: 'sel' carries a test_sel_e code; any other code reports the test as passed.
module alu_compare_unit
    import acc_alu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  test_sel_e    sel,
    output logic         fail
);
    logic is_eq, is_gt, is_lt;

    // Unsigned relations of the two operands
    always_comb begin
        is_eq = (a == b);
        is_gt = (a > b);
        is_lt = (a < b);
    end

    // A false outcome of the selected test is what raises the skip request
    always_comb begin
        case (sel)
            TS_EQ:   fail = ~is_eq;
            TS_GT:   fail = ~is_gt;
            TS_LT:   fail = ~is_lt;
            default: fail = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_alu_skip.sv
// Module acc_alu_skip
// Top of the accumulator ALU. Decodes the opcode and steers A and B to the
// arithmetic, bitwise, shift and compare units. On a capture edge it updates the
// result register for word operations and the skip request for every opcode.
// Assumes: capture is high for one clock per instruction; reset is synchronous and active low.
module acc_alu_skip
    import acc_alu_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned DIR_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] result,
    output logic              skip_req
);
    localparam logic [OP_W-1:0] LOGIC_BASE = OP_AND;

    op_e              op;
    cls_e             cls;
    logic_sel_e       lg_sel;
    test_sel_e        ts_sel;
    logic [OP_W-1:0]  lg_index;
    logic [DATA_W-1:0] arith_y, logic_y, shift_y, word_y;
    logic             test_fail;
    logic             write_en;

    // Decodes the opcode into a class and the unit selects
    always_comb begin
        op       = op_e'(opcode);
        cls      = class_of(op);
        lg_index = opcode - LOGIC_BASE;
        lg_sel   = logic_sel_e'(lg_index[2:0]);
        ts_sel   = test_sel_e'(opcode[1:0]);
        write_en = (cls == CLS_ARITH) || (cls == CLS_LOGIC);
    end

    alu_arith_unit #(.W(DATA_W)) u_arith (
        .a(a_val), .b(b_val), .sub(op == OP_SUB), .y(arith_y)
    );

    alu_bitwise_unit #(.W(DATA_W)) u_logic (
        .a(a_val), .b(b_val), .sel(lg_sel), .y(logic_y)
    );

    alu_shift_unit #(.W(DATA_W)) u_shift (
        .a(a_val), .right(b_val[DIR_BIT]), .y(shift_y)
    );

    alu_compare_unit #(.W(DATA_W)) u_test (
        .a(a_val), .b(b_val), .sel(ts_sel), .fail(test_fail)
    );

    // Picks the word-level outcome for the result register
    always_comb begin
        if (cls == CLS_LOGIC)       word_y = logic_y;
        else if (op == OP_SHIFT)    word_y = shift_y;
        else                        word_y = arith_y;
    end

    // Result register: written on capture by word operations only
    always_ff @(posedge clk) begin
        if (!rst_n)                    result <= '0;
        else if (capture && write_en)  result <= word_y;
    end

    // Skip request: set by a failed test, cleared by any other capture
    always_ff @(posedge clk) begin
        if (!rst_n)       skip_req <= 1'b0;
        else if (capture) skip_req <= (cls == CLS_TEST) && test_fail;
    end

    // Assertions guarding the registers above

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && !skip_req);

    assert_add_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && opcode == 4'b0100) |=> result == DATA_W'($past(a_val) + $past(b_val)));

    assert_not_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && opcode == 4'b1010 && a_val == '0) |=> result == ~$past(b_val));

    assert_eq_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && opcode == 4'b1100) |=> skip_req == ($past(a_val) != $past(b_val)));

    assert_test_keeps_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && opcode[3:2] == 2'b11 && opcode != 4'b1111) |=> $stable(result));

    assert_shift_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && opcode == 4'b1111 && !b_val[DIR_BIT]) |=> result == {$past(a_val[DATA_W-2:0]), 1'b0});

    assert_foreign_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && (opcode[3:2] == 2'b00 || opcode == 4'b0110)) |=> $stable(result));

    assert_skip_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && opcode[3:2] != 2'b11) |=> !skip_req);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(result) && $stable(skip_req));

endmodule

// File: tb/sim_acc_alu_skip.sv
// Bench for acc_alu_skip. A behavioural model is stepped alongside the design
// and compared on every clock, first with directed cases and then with random ones.
module sim_acc_alu_skip;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [7:0] a_val = 8'd0;
    logic [7:0] b_val = 8'd0;
    logic [7:0] result;
    logic       skip_req;

    int n_tests = 0;
    int n_fail  = 0;
    int m_res   = 0;
    int m_skip  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    acc_alu_skip u0 (
        .clk(clk), .rst_n(rst_n), .capture(capture), .opcode(opcode),
        .a_val(a_val), .b_val(b_val), .result(result), .skip_req(skip_req)
    );

    // Requirement that a stimulus exercises
    function automatic string tag_of(input bit rst, input bit cap, input int op, input int a);
        if (!rst) return "R1";
        if (!cap) return "R9";
        case (op)
            4, 5:            return "R2";
            10:              return (a == 0) ? "R4" : "R3";
            7, 8, 9, 11:     return "R3";
            12, 13, 14:      return "R5";
            15:              return "R6";
            default:         return "R7";
        endcase
    endfunction

    // Applies one cycle, advances the model and compares both outputs
    task automatic step(input bit rst, input bit cap, input int op, input int a, input int b);
        string t;
        @(negedge clk);
        rst_n = rst; capture = cap; opcode = 4'(op); a_val = 8'(a); b_val = 8'(b);
        @(posedge clk);
        if (!rst) begin
            m_res = 0; m_skip = 0;
        end else if (cap) begin
            case (op)
                4:  m_res = (a + b) & 255;
                5:  m_res = (a - b + 256) & 255;
                7:  m_res = a & b;
                8:  m_res = a | b;
                9:  m_res = (~(a & b)) & 255;
                10: m_res = (~(a | b)) & 255;
                11: m_res = a ^ b;
                15: m_res = (b % 2 == 1) ? (a / 2) : ((a * 2) & 255);
                default: ;
            endcase
            case (op)
                12: m_skip = (a == b) ? 0 : 1;
                13: m_skip = (a > b) ? 0 : 1;
                14: m_skip = (a < b) ? 0 : 1;
                default: m_skip = 0;
            endcase
        end
        @(negedge clk);
        t = tag_of(rst, cap, op, a);
        n_tests++;
        if (int'(result) != m_res) begin
            n_fail++;
            $display("FAIL %s result op=%0d a=%0d b=%0d: got %0d expected %0d", t, op, a, b, result, m_res);
        end
        n_tests++;
        if (int'(skip_req) != m_skip) begin
            n_fail++;
            $display("FAIL %s skip_req op=%0d a=%0d b=%0d: got %0d expected %0d",
                     (cap && rst && op < 12) ? "R8" : t, op, a, b, skip_req, m_skip);
        end
    endtask

    initial begin
        // R1: reset state
        step(0, 1, 4, 9, 9);
        step(0, 0, 0, 0, 0);
        // R2: wrapping add and borrowing subtract
        step(1, 1, 4, 200, 100);
        step(1, 1, 4, 17, 25);
        step(1, 1, 5, 5, 10);
        step(1, 1, 5, 90, 33);
        // R3: bitwise functions
        step(1, 1, 7, 8'hF0, 8'h3C);
        step(1, 1, 8, 8'hF0, 8'h3C);
        step(1, 1, 9, 8'hF0, 8'h3C);
        step(1, 1, 10, 8'hF0, 8'h3C);
        step(1, 1, 11, 8'hF0, 8'h3C);
        // R4: NOR with A zero is NOT B
        step(1, 1, 10, 0, 8'h5A);
        // R5: tests, both outcomes, boundaries; result held
        step(1, 1, 12, 7, 7);
        step(1, 1, 12, 7, 8);
        step(1, 1, 13, 8, 7);
        step(1, 1, 13, 7, 7);
        step(1, 1, 14, 0, 255);
        step(1, 1, 14, 255, 0);
        step(1, 1, 13, 255, 0);
        // R8: a word op clears the pending skip
        step(1, 1, 14, 3, 3);
        step(1, 1, 4, 1, 1);
        // R6: shifts both ways
        step(1, 1, 15, 8'h81, 0);
        step(1, 1, 15, 8'h81, 1);
        step(1, 1, 15, 8'h81, 8'hFE);
        // R7: foreign opcodes keep the result
        step(1, 1, 13, 1, 2);
        for (int op = 0; op < 4; op++) step(1, 1, op, 123, 45);
        step(1, 1, 6, 99, 98);
        // R9: idle cycles hold outputs, including a set skip
        step(1, 1, 12, 1, 2);
        step(1, 0, 4, 50, 60);
        step(1, 0, 5, 0, 1);
        // random mix
        for (int i = 0; i < 2000; i++)
            step(($urandom % 64) != 0, ($urandom % 4) != 0, int'($urandom % 16),
                 int'($urandom % 256), int'($urandom % 256));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule